// File: doc/BRIEF.md
# Clock Time and Alarm Editor

This block keeps a running 24-hour time of day and a separate alarm time, each stored as six BCD digits. A one-cycle `tick_1hz` strobe advances the running time by one second. Three one-cycle key strobes (set, up, down) and a level `alarm_sel` let a user edit either value. The key strobes are assumed to be already debounced.

A press of set while idle starts an edit session. The cursor appears on the hour-tens digit. Each further set press moves the cursor to the next digit to the right, and the press after the seconds-units digit ends the session. Up and down step the digit under the cursor, wrapping within that digit's legal range. `alarm_sel` chooses which value the keys act on.

While the running time is being edited, it does not count. Two one-cycle pulses come out of the block:
- `alarm_hit` fires when counting brings the time onto the alarm setting.
- `chime` fires at the start of every hour.

Top module: `clock_alarm_editor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time and the alarm become 00:00:00, `editing` becomes 0, `cursor` becomes 7, and `alarm_hit` and `chime` become 0.
- R2: When a `tick_1hz` pulse is accepted, the running time advances by one second on that edge, wrapping from 23:59:59 to 00:00:00. The 24-bit value holds one BCD nibble per digit: hour tens [23:20], hour units [19:16], minute tens [15:12], minute units [11:8], second tens [7:4], second units [3:0].
- R3: A set press while idle enters edit mode with `cursor` = 7. Each further set press moves the cursor through 7, 6, 4, 3, 1, 0, so the separator slots 5 and 2 are never selected. A set press at position 0 leaves edit mode and returns `cursor` to 7.
- R4: Digit positions map as follows: 7 is hour tens, 6 is hour units, 4 is minute tens, 3 is minute units, 1 is second tens and 0 is second units. Up adds 1 and down subtracts 1, each wrapping within the digit's range:
  - hour tens: 0..2
  - hour units: 0..9, or 0..3 when hour tens is 2
  - minute tens and second tens: 0..5
  - minute units and second units: 0..9
- R5: If an edit of hour tens makes it 2 while hour units is above 3, hour units becomes 3 on the same edge.
- R6: With `alarm_sel` = 0 the keys edit the running time and leave the alarm unchanged. With `alarm_sel` = 1 they edit the alarm and leave the running time unchanged.
- R7: While the running time is being edited (`editing` = 1, `alarm_sel` = 0), ticks are ignored. During alarm editing, ticks still advance the time.
- R8: A set press in the same cycle as up or down moves the cursor and changes no digit. Up and down pressed together change nothing. Up or down while idle change nothing.
- R9: `alarm_hit` is high for exactly the one cycle after an accepted tick whose result equals the alarm value held before that edge.
- R10: `chime` is high for the one cycle after an accepted tick that rolls minutes and seconds to 00:00.
- R11: Every digit of the running time always stays within its legal range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| key_set | input | 1 | Set key strobe: start editing or move the cursor |
| key_up | input | 1 | Up key strobe: add 1 to the selected digit |
| key_down | input | 1 | Down key strobe: subtract 1 from the selected digit |
| alarm_sel | input | 1 | Edit target: 0 selects the running time, 1 selects the alarm |
| time_bcd | output | 24 | Running time as BCD hh:mm:ss |
| alarm_bcd | output | 24 | Alarm time as BCD hh:mm:ss |
| editing | output | 1 | High while an edit session is open |
| cursor | output | 3 | Selected digit position |
| alarm_hit | output | 1 | One-cycle alarm match pulse |
| chime | output | 1 | One-cycle top-of-hour pulse |

## Verification
The hour chime and the alarm match can land in the same cycle when the alarm is programmed to a whole hour. The bench sets the alarm to 13:00:00 through the key flow, then ticks the clock on every cycle for a full day. In every cycle it compares both pulses and the time with values derived from a plain seconds count. At 13:00:00 both pulses are expected high together, and at every other hour only the chime is expected.

// File: rtl/tae_pkg.sv
`timescale 1ns/1ps
package tae_pkg;

    localparam int DIGIT_W  = 4;
    localparam int N_DIGITS = 6;
    localparam int BCD_W    = DIGIT_W * N_DIGITS;
    localparam int POS_W    = 3;

    typedef struct packed {
        logic [DIGIT_W-1:0] ht;
        logic [DIGIT_W-1:0] hu;
        logic [DIGIT_W-1:0] mt;
        logic [DIGIT_W-1:0] mu;
        logic [DIGIT_W-1:0] st;
        logic [DIGIT_W-1:0] su;
    } hms_t;

    localparam logic [POS_W-1:0] POS_HT = 3'd7;
    localparam logic [POS_W-1:0] POS_HU = 3'd6;
    localparam logic [POS_W-1:0] POS_MT = 3'd4;
    localparam logic [POS_W-1:0] POS_MU = 3'd3;
    localparam logic [POS_W-1:0] POS_ST = 3'd1;
    localparam logic [POS_W-1:0] POS_SU = 3'd0;

    // Step a digit up or down, wrapping inside 0..lim.
    function automatic logic [DIGIT_W-1:0] wrap_step(
        input logic [DIGIT_W-1:0] d,
        input logic [DIGIT_W-1:0] lim,
        input logic               inc
    );
        if (inc) begin
            return (d >= lim) ? '0 : d + 1'b1;
        end
        return (d == '0 || d > lim) ? lim : d - 1'b1;
    endfunction

    // Next cursor slot, stepping over the two separator slots.
    function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] p);
        case (p)
            POS_HT:  return POS_HU;
            POS_HU:  return POS_MT;
            POS_MT:  return POS_MU;
            POS_MU:  return POS_ST;
            POS_ST:  return POS_SU;
            default: return POS_HT;
        endcase
    endfunction

    // One second later, in 24-hour BCD.
    function automatic hms_t sec_step(input hms_t t);
        hms_t n;
        n = t;
        if (t.su != 4'd9) begin
            n.su = t.su + 1'b1;
        end else begin
            n.su = '0;
            if (t.st != 4'd5) begin
                n.st = t.st + 1'b1;
            end else begin
                n.st = '0;
                if (t.mu != 4'd9) begin
                    n.mu = t.mu + 1'b1;
                end else begin
                    n.mu = '0;
                    if (t.mt != 4'd5) begin
                        n.mt = t.mt + 1'b1;
                    end else begin
                        n.mt = '0;
                        if (t.ht == 4'd2 && t.hu == 4'd3) begin
                            n.ht = '0;
                            n.hu = '0;
                        end else if (t.hu == 4'd9) begin
                            n.hu = '0;
                            n.ht = t.ht + 1'b1;
                        end else begin
                            n.hu = t.hu + 1'b1;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/tae_cursor.sv
`timescale 1ns/1ps
module tae_cursor
    import tae_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_set,
    output logic             editing,
    output logic [POS_W-1:0] pos
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            editing <= 1'b0;
            pos     <= POS_HT;
        end else if (key_set) begin
            if (!editing) begin
                editing <= 1'b1;
                pos     <= POS_HT;
            end else if (pos == POS_SU) begin
                editing <= 1'b0;
                pos     <= POS_HT;
            end else begin
                pos <= next_pos(pos);
            end
        end
    end

endmodule

// File: rtl/tae_digit_editor.sv
`timescale 1ns/1ps
module tae_digit_editor
    import tae_pkg::*;
(
    input  hms_t             cur,
    input  logic [POS_W-1:0] pos,
    input  logic             step_up,
    input  logic             step_dn,
    output hms_t             nxt
);

    logic [DIGIT_W-1:0] hu_lim;

    assign hu_lim = (cur.ht == 4'd2) ? 4'd3 : 4'd9;

    always_comb begin
        nxt = cur;
        if (step_up ^ step_dn) begin
            case (pos)
                POS_HT: begin
                    nxt.ht = wrap_step(cur.ht, 4'd2, step_up);
                    if (nxt.ht == 4'd2 && cur.hu > 4'd3) begin
                        nxt.hu = 4'd3;
                    end
                end
                POS_HU:  nxt.hu = wrap_step(cur.hu, hu_lim, step_up);
                POS_MT:  nxt.mt = wrap_step(cur.mt, 4'd5, step_up);
                POS_MU:  nxt.mu = wrap_step(cur.mu, 4'd9, step_up);
                POS_ST:  nxt.st = wrap_step(cur.st, 4'd5, step_up);
                POS_SU:  nxt.su = wrap_step(cur.su, 4'd9, step_up);
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/tae_timekeeper.sv
`timescale 1ns/1ps
module tae_timekeeper
    import tae_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  hms_t edit_val,
    output hms_t now,
    output hms_t adv,
    output logic stepping,
    output logic chime
);

    logic hour_edge;

    assign adv       = sec_step(now);
    assign stepping  = tick && !hold;
    assign hour_edge = (now.mt == 4'd5) && (now.mu == 4'd9) &&
                       (now.st == 4'd5) && (now.su == 4'd9);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now   <= '0;
            chime <= 1'b0;
        end else begin
            chime <= stepping && hour_edge;
            if (hold) begin
                now <= edit_val;
            end else if (tick) begin
                now <= adv;
            end
        end
    end

endmodule

// File: rtl/clock_alarm_editor.sv
`timescale 1ns/1ps
module clock_alarm_editor
    import tae_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             key_set,
    input  logic             key_up,
    input  logic             key_down,
    input  logic             alarm_sel,
    output logic [BCD_W-1:0] time_bcd,
    output logic [BCD_W-1:0] alarm_bcd,
    output logic             editing,
    output logic [POS_W-1:0] cursor,
    output logic             alarm_hit,
    output logic             chime
);

    localparam int N_TGT = 2;  // 0: running time, 1: alarm

    logic             edit_on;
    logic [POS_W-1:0] pos;
    logic             step_ok;
    hms_t             time_q;
    hms_t             alarm_q;
    hms_t             time_adv;
    logic             stepping;
    hms_t             tgt_cur [N_TGT];
    hms_t             tgt_nxt [N_TGT];

    tae_cursor u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_set (key_set),
        .editing (edit_on),
        .pos     (pos)
    );

    // set wins over up/down; digits move only inside a session
    assign step_ok    = edit_on && !key_set;
    assign tgt_cur[0] = time_q;
    assign tgt_cur[1] = alarm_q;

    for (genvar g = 0; g < N_TGT; g++) begin : g_edit
        logic sel;
        assign sel = (alarm_sel == g[0]);
        tae_digit_editor u_ed (
            .cur     (tgt_cur[g]),
            .pos     (pos),
            .step_up (step_ok && sel && key_up),
            .step_dn (step_ok && sel && key_down),
            .nxt     (tgt_nxt[g])
        );
    end

    tae_timekeeper u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .hold     (edit_on && !alarm_sel),
        .edit_val (tgt_nxt[0]),
        .now      (time_q),
        .adv      (time_adv),
        .stepping (stepping),
        .chime    (chime)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q   <= '0;
            alarm_hit <= 1'b0;
        end else begin
            alarm_q   <= tgt_nxt[1];
            alarm_hit <= stepping && (time_adv == alarm_q);
        end
    end

    assign time_bcd  = time_q;
    assign alarm_bcd = alarm_q;
    assign editing   = edit_on;
    assign cursor    = pos;

endmodule

// File: rtl/tae_checker.sv
`timescale 1ns/1ps
module tae_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        key_set,
    input logic        key_up,
    input logic        key_down,
    input logic        alarm_sel,
    input logic [23:0] time_bcd,
    input logic [23:0] alarm_bcd,
    input logic        editing,
    input logic [2:0]  cursor,
    input logic        alarm_hit,
    input logic        chime
);

    assert_digits_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        time_bcd[23:20] <= 4'd2 && time_bcd[19:16] <= 4'd9 &&
        !(time_bcd[23:20] == 4'd2 && time_bcd[19:16] > 4'd3) &&
        time_bcd[15:12] <= 4'd5 && time_bcd[11:8] <= 4'd9 &&
        time_bcd[7:4] <= 4'd5 && time_bcd[3:0] <= 4'd9);

    assert_skip_dash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        editing |-> (cursor != 3'd5 && cursor != 3'd2));

    assert_enter_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!editing && key_set) |=> (editing && cursor == 3'd7));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (editing && !alarm_sel && !key_up && !key_down) |=> $stable(time_bcd));

    assert_alarm_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(editing && alarm_sel) |=> $stable(alarm_bcd));

    assert_chime_on_hour_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chime |-> (time_bcd[15:0] == 16'h0000));

    assert_hit_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(tick_1hz && !(editing && !alarm_sel)));

endmodule

bind clock_alarm_editor tae_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .key_set   (key_set),
    .key_up    (key_up),
    .key_down  (key_down),
    .alarm_sel (alarm_sel),
    .time_bcd  (time_bcd),
    .alarm_bcd (alarm_bcd),
    .editing   (editing),
    .cursor    (cursor),
    .alarm_hit (alarm_hit),
    .chime     (chime)
);

// File: tb/sim_clock_alarm_editor.sv
`timescale 1ns/1ps
module sim_clock_alarm_editor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        key_set = 1'b0;
    logic        key_up = 1'b0;
    logic        key_down = 1'b0;
    logic        alarm_sel = 1'b0;
    logic [23:0] time_bcd;
    logic [23:0] alarm_bcd;
    logic        editing;
    logic [2:0]  cursor;
    logic        alarm_hit;
    logic        chime;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clock_alarm_editor u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .key_set(key_set),
        .key_up(key_up), .key_down(key_down), .alarm_sel(alarm_sel),
        .time_bcd(time_bcd), .alarm_bcd(alarm_bcd), .editing(editing),
        .cursor(cursor), .alarm_hit(alarm_hit), .chime(chime)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one-cycle strobe on any mix of keys and tick; returns once outputs settled
    task automatic strobe(input logic s, input logic u, input logic d, input logic t);
        @(negedge clk);
        key_set = s; key_up = u; key_down = d; tick_1hz = t;
        @(negedge clk);
        key_set = 1'b0; key_up = 1'b0; key_down = 1'b0; tick_1hz = 1'b0;
    endtask

    function automatic logic [23:0] to_bcd(input int s);
        int h, m, x;
        h = s / 3600; m = (s / 60) % 60; x = s % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int shifts [6] = '{20, 16, 12, 8, 4, 0};
        int lims   [6] = '{2, 9, 5, 9, 5, 9};
        int slots  [6] = '{7, 6, 4, 3, 1, 0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 time", time_bcd, 24'h0);
        check("R1 alarm", alarm_bcd, 24'h0);
        check("R1 editing", editing, 0);
        check("R1 cursor", cursor, 7);
        check("R1 pulses", {alarm_hit, chime}, 0);

        // R8: up/down while idle change nothing
        strobe(0, 1, 0, 0);
        check("R8 idle up", time_bcd, 24'h0);
        strobe(0, 0, 1, 0);
        check("R8 idle down", time_bcd, 24'h0);

        // R3/R4: sweep every digit of the running time, both directions
        alarm_sel = 1'b0;
        strobe(1, 0, 0, 0);
        check("R3 enter", {editing, cursor}, {1'b1, 3'd7});
        strobe(0, 0, 0, 1);
        check("R7 frozen", time_bcd, 24'h0);
        for (int k = 0; k < 6; k++) begin
            int e;
            check("R3 cursor order", cursor, slots[k]);
            e = 0;
            for (int j = 0; j < 12; j++) begin
                strobe(0, 1, 0, 0);
                e = (e == lims[k]) ? 0 : e + 1;
                check("R4 up wrap", (time_bcd >> shifts[k]) & 24'hF, e);
            end
            for (int j = 0; j < 12; j++) begin
                strobe(0, 0, 1, 0);
                e = (e == 0) ? lims[k] : e - 1;
                check("R4 down wrap", (time_bcd >> shifts[k]) & 24'hF, e);
            end
            strobe(1, 0, 0, 0);
        end
        check("R3 exit", {editing, cursor}, {1'b0, 3'd7});
        check("R6 alarm kept", alarm_bcd, 24'h0);

        // R5: hour units clamp
        strobe(1, 0, 0, 0);
        strobe(1, 0, 0, 0);
        repeat (5) strobe(0, 1, 0, 0);
        check("R4 hour units", time_bcd, 24'h050000);
        repeat (5) strobe(1, 0, 0, 0);
        check("R3 exit again", editing, 0);
        strobe(1, 0, 0, 0);
        strobe(0, 1, 0, 0);
        strobe(0, 1, 0, 0);
        check("R5 clamp", time_bcd, 24'h230000);
        strobe(0, 0, 1, 0);
        check("R5 after down", time_bcd, 24'h130000);

        // R8: set beats up; up with down is a no-op
        strobe(1, 1, 0, 0);
        check("R8 set+up cursor", cursor, 6);
        check("R8 set+up digits", time_bcd, 24'h130000);
        strobe(0, 1, 1, 0);
        check("R8 up+down", time_bcd, 24'h130000);
        repeat (5) strobe(1, 0, 0, 0);
        check("R3 idle", editing, 0);

        // R6/R7: alarm edit keeps the clock running
        alarm_sel = 1'b1;
        strobe(1, 0, 0, 0);
        strobe(0, 0, 0, 1);
        check("R7 alarm edit ticks", time_bcd, 24'h130001);
        strobe(0, 1, 0, 0);
        check("R6 alarm edited", alarm_bcd, 24'h100000);
        check("R6 time kept", time_bcd, 24'h130001);
        repeat (6) strobe(1, 0, 0, 0);
        alarm_sel = 1'b0;

        // R1: reset clears both values
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset", {time_bcd, alarm_bcd}, 48'h0);

        // program alarm 13:00:00 through the keys
        alarm_sel = 1'b1;
        strobe(1, 0, 0, 0);
        strobe(0, 1, 0, 0);
        strobe(1, 0, 0, 0);
        repeat (3) strobe(0, 1, 0, 0);
        repeat (5) strobe(1, 0, 0, 0);
        alarm_sel = 1'b0;
        check("R6 alarm programmed", alarm_bcd, 24'h130000);
        check("R1 time still zero", time_bcd, 24'h0);

        // R2/R9/R10: one full day, tick every cycle
        @(negedge clk); tick_1hz = 1'b1;
        for (int i = 1; i <= 86400; i++) begin
            @(negedge clk);
            check("R2 count", time_bcd, to_bcd(i % 86400));
            check("R10 chime", chime, (i % 3600) == 0);
            check("R9 alarm hit", alarm_hit, (i % 86400) == 46800);
        end
        tick_1hz = 1'b0;
        @(negedge clk);
        check("R9 pulse ends", {alarm_hit, chime}, 0);
        finish_run();
    end

endmodule